// File: doc/BRIEF.md
# Three-Phase Oversampled Early/Late Detector with Window Aligner

This block recovers serial data from a stream sampled several times per bit. Each bit is judged from three of its samples, taken at nominal phases of 60, 180 and 300 degrees after the ideal bit boundary. The 180-degree sample is the recovered bit. Comparing the 300-degree sample with the other two tells whether the receive clock is early or late. The result is one correction pulse per bit, in one of two directions: advance ("up") or retard ("down").

The input is a chunk of `SPB` samples per bit period (six by default, 60-degree spacing), delivered with a valid strobe. The three taps are picked out of a two-chunk history by a window index. With `track_en` low, the window stays where it is and the up/down pulses can steer an external oscillator. With `track_en` high, the block acts as a fixed-frequency aligner. A signed vote counter adds one for each up and subtracts one for each down. When the net count reaches plus or minus `VOTE_TH`, the window moves one position, and when it wraps it slips a bit.

Top module: `tri_phase_align`

## Requirements
- R1: A synchronous active-low reset sets `win_idx` to `SPB/2` (3 by default), clears the vote counter and any pending skip, and holds `data_valid`, `data_two`, `up`, `down` and `slip` low.
- R2: `samp_in[i]` is the i-th sample of the chunk in time order, with bit 0 the earliest. The history is the previous chunk at positions 0..SPB-1 and the current chunk at SPB..2*SPB-1. For a window w, the three taps are the samples at history positions w+1, w+3 and w+5. For each valid frame that is not skipped, `data_valid` pulses one cycle later and `data_out[0]` equals the tap at w+3 (the 180-degree tap).
- R3: When the 60-degree tap differs from the 180-degree tap and the 180-degree tap equals the 300-degree tap, `up` pulses together with that bit.
- R4: When the 180-degree tap differs from the 300-degree tap, `down` pulses, whatever the 60-degree tap is.
- R5: When all three taps agree, neither `up` nor `down` pulses.
- R6: `up` and `down` are never high together, and each is high only in a cycle where `data_valid` is high.
- R7: With `track_en` high, the counter adds one for each up and subtracts one for each down. When the count reaches +`VOTE_TH`, the window index increases by one and the counter clears. Otherwise the window is unchanged.
- R8: When the count reaches -`VOTE_TH`, the window index decreases by one and the counter clears.
- R9: An advance from index SPB-1 wraps the index to 0. The next valid frame then gives no bit: `data_valid` stays low, `slip` pulses, and that frame casts no vote.
- R10: A retard from index 0 wraps the index to SPB-1. In that same frame two bits are delivered: `data_two` and `slip` pulse, `data_out[0]` is the bit of window 0 and `data_out[1]` is the history sample at position 2*SPB-1-3 (the 180-degree tap of window SPB-1).
- R11: With `track_en` low, the window never moves and the vote counter is held at zero. Up and down pulses are still produced.
- R12: In a cycle with `samp_valid` low, the history, window and counter keep their values, and the next cycle shows no `data_valid`, `up`, `down` or `slip`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_in | input | SPB | One bit period of samples, bit 0 earliest |
| samp_valid | input | 1 | `samp_in` carries a new chunk this cycle |
| track_en | input | 1 | 1: aligner moves the window; 0: window held |
| data_out | output | 2 | Recovered bit(s); [0] earlier, [1] used only with `data_two` |
| data_valid | output | 1 | At least one bit recovered this cycle |
| data_two | output | 1 | Two bits recovered this cycle (retard wrap) |
| up | output | 1 | Advance correction for this bit |
| down | output | 1 | Retard correction for this bit |
| win_idx | output | $clog2(SPB) | Current window index |
| slip | output | 1 | This period gave zero or two bits |

## Verification
The bound checker watches the pulse rules on every cycle. Up and down must never overlap and must always come with a bit. A double-bit cycle must be a retard at the last index. A skipped frame must sit at index 0 with no correction. The window may move by at most one position per frame, and it must stay frozen when `track_en` is low or no chunk arrives. Whether the recovered bit is the right tap, whether up and down are chosen correctly for a given pattern, and whether the window moves on exactly the `VOTE_TH`-th net vote can only be shown by the bench. It drives drifting bit streams that force both wrap directions, and it compares every output against a reference model built from the requirements.

// File: rtl/tpd_pkg.sv
// Shared types for the three-phase early/late detector.
package tpd_pkg;

    // Phase decision for one bit period.
    typedef enum logic [1:0] {
        JUDGE_HOLD    = 2'd0,
        JUDGE_ADVANCE = 2'd1,
        JUDGE_RETARD  = 2'd2
    } judge_t;

    // The three taps of one bit: 60, 180 and 300 degrees.
    typedef struct packed {
        logic early;
        logic mid;
        logic late;
    } triplet_t;

endpackage

// File: rtl/tpd_tap_select.sv
// Picks the three taps of the current window out of the two-chunk history.
// It also gives the 180-degree tap of window SPB-1, which is needed when a
// retard wraps the window and a second bit is delivered.
// Assumes SPB is a multiple of 6 and that win is below SPB.
module tpd_tap_select
    import tpd_pkg::*;
#(
    parameter int SPB = 6,
    localparam int WW = $clog2(SPB),
    localparam int HW = 2 * SPB
) (
    input  logic [HW-1:0] hist,
    input  logic [WW-1:0] win,
    output triplet_t      taps,
    output logic          back_mid
);
    localparam int PH       = SPB / 6;
    localparam int IW       = $clog2(HW);
    localparam int BACK_MID = SPB - 1 + 3 * PH;

    logic [IW-1:0] idx_early, idx_mid, idx_late;

    // Tap positions relative to the window boundary.
    always_comb begin
        idx_early = IW'(win) + IW'(PH);
        idx_mid   = IW'(win) + IW'(3 * PH);
        idx_late  = IW'(win) + IW'(5 * PH);
    end

    // Read the taps out of the history.
    always_comb begin
        taps.early = hist[idx_early];
        taps.mid   = hist[idx_mid];
        taps.late  = hist[idx_late];
        back_mid   = hist[BACK_MID];
    end
endmodule

// File: rtl/tpd_phase_judge.sv
// Early/late decision for one triplet. A difference between the 180 and
// 300 degree taps means retard, and it wins over everything else. Otherwise,
// a difference between the 60 and 180 degree taps means advance.
module tpd_phase_judge
    import tpd_pkg::*;
(
    input  triplet_t taps,
    output judge_t   judge
);
    // Retard has priority over advance.
    always_comb begin
        if (taps.mid != taps.late)
            judge = JUDGE_RETARD;
        else if (taps.early != taps.mid)
            judge = JUDGE_ADVANCE;
        else
            judge = JUDGE_HOLD;
    end
endmodule

// File: rtl/tpd_window_ctl.sv
// Vote counter and window index for the fixed-frequency aligner.
// It moves the window one step after VOTE_TH net votes. A forward wrap
// marks the next frame to be skipped. A backward wrap is flagged for the
// current frame, which then delivers two bits.
// Assumes the judge input belongs to the current frame.
module tpd_window_ctl
    import tpd_pkg::*;
#(
    parameter int SPB     = 6,
    parameter int VOTE_TH = 4,
    localparam int WW = $clog2(SPB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_valid,
    input  logic          track_en,
    input  judge_t        judge,
    output logic [WW-1:0] win,
    output logic          skip_pend,
    output logic          bit_now,
    output logic          wrap_back
);
    localparam int CW = $clog2(VOTE_TH) + 2;
    localparam logic [WW-1:0]        CENTRE = WW'(SPB / 2);
    localparam logic [WW-1:0]        LAST   = WW'(SPB - 1);
    localparam logic signed [CW-1:0] ONE    = CW'(1);
    localparam logic signed [CW-1:0] TH_P   = CW'(VOTE_TH);
    localparam logic signed [CW-1:0] TH_N   = -TH_P;

    logic signed [CW-1:0] votes, votes_sum;
    logic fire_fwd, fire_back;

    assign bit_now = frame_valid & ~skip_pend;

    // Counter value after this frame's vote.
    always_comb begin
        votes_sum = votes;
        case (judge)
            JUDGE_ADVANCE: votes_sum = votes + ONE;
            JUDGE_RETARD:  votes_sum = votes - ONE;
            default: ;
        endcase
    end

    // Threshold detection and backward-wrap flag for this frame.
    always_comb begin
        fire_fwd  = bit_now & track_en & (votes_sum == TH_P);
        fire_back = bit_now & track_en & (votes_sum == TH_N);
        wrap_back = fire_back & (win == '0);
    end

    // Window, counter and skip state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win       <= CENTRE;
            votes     <= '0;
            skip_pend <= 1'b0;
        end else if (frame_valid) begin
            if (skip_pend) begin
                skip_pend <= 1'b0;
            end else if (!track_en) begin
                votes <= '0;
            end else if (fire_fwd) begin
                votes <= '0;
                if (win == LAST) begin
                    win       <= '0;
                    skip_pend <= 1'b1;
                end else begin
                    win <= win + WW'(1);
                end
            end else if (fire_back) begin
                votes <= '0;
                win   <= (win == '0) ? LAST : win - WW'(1);
            end else begin
                votes <= votes_sum;
            end
        end
    end
endmodule

// File: rtl/tri_phase_align.sv
// Three-phase oversampled early/late detector with window aligner.
// Takes one chunk of SPB samples per bit period, keeps the previous chunk as
// history, judges the current window and registers the recovered bit(s), the
// correction pulses and the slip flag. All outputs change one cycle after the
// chunk that caused them. Assumes SPB is a multiple of 6.
module tri_phase_align
    import tpd_pkg::*;
#(
    parameter int SPB     = 6,
    parameter int VOTE_TH = 4,
    localparam int WW = $clog2(SPB)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [SPB-1:0] samp_in,
    input  logic           samp_valid,
    input  logic           track_en,
    output logic [1:0]     data_out,
    output logic           data_valid,
    output logic           data_two,
    output logic           up,
    output logic           down,
    output logic [WW-1:0]  win_idx,
    output logic           slip
);
    logic [SPB-1:0]   prev_chunk;
    logic [2*SPB-1:0] hist;
    triplet_t         taps;
    logic             back_mid;
    judge_t           judge;
    logic [WW-1:0]    win;
    logic             skip_pend, bit_now, wrap_back;

    assign hist    = {samp_in, prev_chunk};
    assign win_idx = win;

    // Keep the previous chunk as the older half of the history.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_chunk <= '0;
        else if (samp_valid)
            prev_chunk <= samp_in;
    end

    tpd_tap_select #(.SPB(SPB)) u_taps (
        .hist     (hist),
        .win      (win),
        .taps     (taps),
        .back_mid (back_mid)
    );

    tpd_phase_judge u_judge (
        .taps  (taps),
        .judge (judge)
    );

    tpd_window_ctl #(.SPB(SPB), .VOTE_TH(VOTE_TH)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_valid (samp_valid),
        .track_en    (track_en),
        .judge       (judge),
        .win         (win),
        .skip_pend   (skip_pend),
        .bit_now     (bit_now),
        .wrap_back   (wrap_back)
    );

    // Register the bit outputs, correction pulses and slip flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_out   <= '0;
            data_valid <= 1'b0;
            data_two   <= 1'b0;
            up         <= 1'b0;
            down       <= 1'b0;
            slip       <= 1'b0;
        end else begin
            data_valid <= bit_now;
            data_two   <= wrap_back;
            up         <= bit_now & (judge == JUDGE_ADVANCE);
            down       <= bit_now & (judge == JUDGE_RETARD);
            slip       <= (samp_valid & skip_pend) | wrap_back;
            if (bit_now)
                data_out <= wrap_back ? {back_mid, taps.mid} : {1'b0, taps.mid};
        end
    end
endmodule

// File: rtl/tpd_align_chk.sv
// Property checker for tri_phase_align, attached by bind. It observes only
// the top-level ports, plus one register of its own that holds the
// previous window index.
module tpd_align_chk #(
    parameter int SPB = 6,
    localparam int WW = $clog2(SPB)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          samp_valid,
    input logic          track_en,
    input logic          data_valid,
    input logic          data_two,
    input logic          up,
    input logic          down,
    input logic [WW-1:0] win_idx,
    input logic          slip
);
    localparam logic [WW-1:0] LAST = WW'(SPB - 1);

    logic [WW-1:0] win_q, win_fwd, win_back;

    // Window index of the previous cycle.
    always_ff @(posedge clk) win_q <= win_idx;

    // The two neighbours of the previous index.
    always_comb begin
        win_fwd  = (win_q == LAST) ? '0 : win_q + WW'(1);
        win_back = (win_q == '0) ? LAST : win_q - WW'(1);
    end

    assert_updown_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(up && down));

    assert_corr_with_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (up || down) |-> data_valid);

    assert_double_at_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        data_two |-> (slip && data_valid && down && win_idx == LAST));

    assert_skip_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (slip && !data_valid) |-> (!up && !down && !data_two && win_idx == '0));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !samp_valid |=> (win_idx == win_q && !data_valid && !slip));

    assert_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (samp_valid && !track_en) |=> (win_idx == win_q));

    assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        samp_valid |=> (win_idx == win_q || win_idx == win_fwd || win_idx == win_back));

    assert_index_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        win_idx <= LAST);
endmodule

bind tri_phase_align tpd_align_chk #(.SPB(SPB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .samp_valid (samp_valid),
    .track_en   (track_en),
    .data_valid (data_valid),
    .data_two   (data_two),
    .up         (up),
    .down       (down),
    .win_idx    (win_idx),
    .slip       (slip)
);

// File: tb/sim_tri_phase_align.sv
// Bench for tri_phase_align: directed corner cases plus seeded random and
// drifting streams, compared against a reference model built from the
// requirements.
module sim_tri_phase_align;
    localparam int SPB = 6;
    localparam int TH  = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [SPB-1:0] samp_in;
    logic           samp_valid;
    logic           track_en;
    logic [1:0]     data_out;
    logic           data_valid, data_two, up, down, slip;
    logic [2:0]     win_idx;

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state.
    logic [SPB-1:0] m_prev;
    int             m_w, m_cnt;
    logic           m_skip;
    logic           e_valid, e_up, e_dn, e_two, e_slip;
    logic [1:0]     e_data;
    int             seen_skip = 0, seen_two = 0, seen_fwd = 0, seen_back = 0;

    // Stream generator state.
    logic g_bit = 1'b0;
    int   g_rem = 0, g_cnt = 0;

    always #4 clk = ~clk;

    tri_phase_align #(.SPB(SPB), .VOTE_TH(TH)) u0 (
        .clk(clk), .rst_n(rst_n), .samp_in(samp_in), .samp_valid(samp_valid),
        .track_en(track_en), .data_out(data_out), .data_valid(data_valid),
        .data_two(data_two), .up(up), .down(down), .win_idx(win_idx), .slip(slip)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Expected outputs for one input cycle, then advance the model state.
    task automatic model(input logic [SPB-1:0] s, input logic v, input logic t);
        logic [2*SPB-1:0] h;
        logic a, b, c, dn, ad;
        int nc;
        h = {s, m_prev};
        e_valid = 0; e_up = 0; e_dn = 0; e_two = 0; e_slip = 0;
        if (v) begin
            if (m_skip) begin
                m_skip = 0; e_slip = 1; seen_skip++;
            end else begin
                a = h[m_w + 1]; b = h[m_w + 3]; c = h[m_w + 5];
                dn = b ^ c; ad = (a ^ b) & ~dn;
                e_valid = 1; e_up = ad; e_dn = dn; e_data = {1'b0, b};
                if (!t) m_cnt = 0;
                else begin
                    nc = m_cnt + (ad ? 1 : 0) - (dn ? 1 : 0);
                    if (nc == TH) begin
                        m_cnt = 0; seen_fwd++;
                        if (m_w == SPB - 1) begin m_w = 0; m_skip = 1; end
                        else m_w++;
                    end else if (nc == -TH) begin
                        m_cnt = 0; seen_back++;
                        if (m_w == 0) begin
                            m_w = SPB - 1; e_two = 1; e_slip = 1;
                            e_data = {h[2*SPB-4], b}; seen_two++;
                        end else m_w--;
                    end else m_cnt = nc;
                end
            end
            m_prev = s;
        end
    endtask

    // Drive one cycle, then compare every output after the edge.
    task automatic step(input logic [SPB-1:0] s, input logic v, input logic t);
        @(negedge clk);
        samp_in = s; samp_valid = v; track_en = t;
        model(s, v, t);
        @(posedge clk); #1;
        chk(v ? "R2 data_valid" : "R12 idle data_valid", data_valid, e_valid);
        chk(v ? "R3 up" : "R12 idle up", up, e_up);
        chk(v ? "R4 down" : "R12 idle down", down, e_dn);
        chk("R10 data_two", data_two, e_two);
        chk(e_two ? "R10 slip" : "R9 slip", slip, e_slip);
        chk(t ? "R7 R8 window index" : "R11 window frozen", win_idx, m_w);
        chk("R6 exclusive", up & down, 0);
        if (e_valid && !e_up && !e_dn) chk("R5 no correction", up | down, 0);
        if (e_valid) chk("R2 data_out", data_out, e_data);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; samp_valid = 0; track_en = 0; samp_in = '0;
        repeat (2) @(posedge clk);
        #1;
        m_prev = '0; m_w = SPB / 2; m_cnt = 0; m_skip = 0;
        chk("R1 reset window", win_idx, SPB / 2);
        chk("R1 reset pulses", {data_valid, data_two, up, down, slip}, 0);
        @(negedge clk); rst_n = 1;
    endtask

    // Next chunk. mode 0: random; 1: alternating bits, every 8th one sample
    // long; 2: alternating bits, every 8th one sample short.
    task automatic chunk(input int mode, output logic [SPB-1:0] c);
        for (int i = 0; i < SPB; i++) begin
            if (mode == 0) c[i] = 1'($urandom);
            else begin
                if (g_rem == 0) begin
                    g_bit = ~g_bit; g_cnt++;
                    g_rem = (g_cnt % 8 == 0) ? ((mode == 1) ? SPB + 1 : SPB - 1) : SPB;
                end
                c[i] = g_bit; g_rem--;
            end
        end
    endtask

    initial begin
        logic [SPB-1:0] c;
        int unused_seed;
        unused_seed = $urandom(32'h0C0FFEE5);
        rst_n = 1; samp_in = '0; samp_valid = 0; track_en = 0;
        do_reset();

        // Directed taps at window 3 after reset (history low half is zero).
        step(6'b000000, 1, 0);   // all agree: R5
        step(6'b000101, 1, 0);   // 60 differs, 180 == 300 at w=3: R3
        step(6'b000100, 1, 0);   // 60 == 180, 300 differs: R4 priority
        step(6'b111111, 0, 0);   // idle: R12
        step(6'b111000, 1, 0);

        // Random chunks with gaps, tracking on and off.
        for (int k = 0; k < 600; k++) begin
            chunk(0, c);
            step(c, ($urandom % 5) != 0, ($urandom % 3) != 0);
        end

        // Forward drift: forces advances and forward wraps (R7, R9).
        for (int k = 0; k < 900; k++) begin
            chunk(1, c);
            step(c, ($urandom % 8) != 0, 1);
        end

        // Drift with tracking off: window must hold (R11).
        for (int k = 0; k < 100; k++) begin
            chunk(1, c);
            step(c, 1, 0);
        end

        // Backward drift: retards and backward wraps (R8, R10).
        for (int k = 0; k < 900; k++) begin
            chunk(2, c);
            step(c, ($urandom % 8) != 0, 1);
        end

        // Reset again mid-stream (R1).
        do_reset();
        for (int k = 0; k < 50; k++) begin
            chunk(2, c);
            step(c, 1, 1);
        end

        chk("R9 forward wrap reached", seen_skip > 0, 1);
        chk("R10 backward wrap reached", seen_two > 0, 1);
        chk("R7 advance reached", seen_fwd > 0, 1);
        chk("R8 retard reached", seen_back > 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule